// File: doc/BRIEF.md
# Upper-Immediate, Jump-Target and Compare Execute Unit

This unit is the combinational execute slice of a 32-bit integer core that handles the instructions used to build wide constants, PC-relative addresses, register-indirect jump targets and set-less-than results. A decoder upstream supplies a small operation code, the PC of the instruction, both source register values, the 20-bit upper immediate, the 12-bit immediate and the destination register index. The unit returns the value to write back, a write-enable, a redirect flag and the redirect target.

Pairing an upper-immediate instruction with a 12-bit add or register jump lets software reach any 32-bit address. At PC 0x00000008, the upper-immediate PC add with 0x10000 gives 0x10000008, and an add of 0x018 gives 0x10000020. With 0x7FFFF in the first step and a jump offset of 0x010, the pair redirects to 0x7FFFF018. Because the unit is purely combinational, every output follows its inputs in the same cycle.

Operation codes (`op_i`): 0 idle, 1 upper-immediate load, 2 upper-immediate PC add, 3 add immediate, 4 register jump, 5 signed less-than, 6 unsigned less-than, 7 signed less-than immediate, 8 unsigned less-than immediate. Codes 9 to 15 are unused.

Top module: `ue_exec`

## Requirements
- R1: With op 1, `wr_val_o` equals `imm20_i` placed in bits 31..12, with bits 11..0 zero.
- R2: With op 2, `wr_val_o` equals `pc_i` plus `imm20_i` placed in bits 31..12, with bits 11..0 zero. The sum wraps modulo 2^32.
- R3: With op 3, `wr_val_o` equals `rs1_i` plus `imm12_i` sign-extended to 32 bits.
- R4: With op 4, `redirect_o` is 1, `target_o` equals `rs1_i` plus sign-extended `imm12_i` with bit 0 forced to 0, and `wr_val_o` equals `pc_i` plus 4.
- R5: With op 5 or op 6, `wr_val_o` is 1 when `rs1_i` is less than `rs2_i`, and 0 otherwise. Op 5 compares the two values as two's-complement numbers and op 6 compares them as unsigned numbers.
- R6: With op 7 or op 8, the second operand is `imm12_i` sign-extended to 32 bits. Op 7 compares signed and op 8 compares that extended value unsigned. The result is 1 or 0 as in R5.
- R7: `wr_en_o` is 1 for ops 1 to 8 when `rd_i` is nonzero. It is 0 whenever `rd_i` is 0, while `wr_val_o` still shows the computed value.
- R8: For every op other than 4, `redirect_o` and `target_o` are 0. For op 0 and ops 9 to 15, `wr_val_o` and `wr_en_o` are also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Decoded operation code |
| pc_i | input | 32 | PC of the current instruction |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| imm20_i | input | 20 | Upper immediate field |
| imm12_i | input | 12 | 12-bit immediate field |
| rd_i | input | 5 | Destination register index |
| wr_val_o | output | 32 | Write-back value |
| wr_en_o | output | 1 | Write-back enable |
| redirect_o | output | 1 | Take the jump |
| target_o | output | 32 | Jump target address |

## Verification
The checker assumes that the inputs are settled, two-state values whenever it samples them. It also assumes that any op code outside 0 to 8 is a legal idle request, not an error. The bench changes inputs only on the rising edge of its clock and compares outputs on the falling edge. It drives every op code, including the unused ones, so the rules for idle outputs and for a zero destination index are checked across the whole input space.

// File: rtl/ue_pkg.sv
// Package for the execute unit: widths and the operation code set.
// Assumes a 32-bit data path and a 4-bit operation code from decode.
package ue_pkg;
    localparam int XLEN   = 32;
    localparam int UIMM_W = 20;
    localparam int SIMM_W = 12;
    localparam int RIDX_W = 5;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE  = 4'd0,
        OP_LUI   = 4'd1,
        OP_AUIPC = 4'd2,
        OP_ADDI  = 4'd3,
        OP_JALR  = 4'd4,
        OP_SLT   = 4'd5,
        OP_SLTU  = 4'd6,
        OP_SLTI  = 4'd7,
        OP_SLTIU = 4'd8
    } ue_op_e;
endpackage

// File: rtl/ue_imm.sv
// Immediate former: places the upper immediate above a cleared low field
// and sign-extends the short immediate. Assumes UW + low field == W.
module ue_imm #(
    parameter int W  = 32,
    parameter int UW = 20,
    parameter int SW = 12
) (
    input  logic [UW-1:0] uimm_i,
    input  logic [SW-1:0] simm_i,
    output logic [W-1:0]  upper_o,
    output logic [W-1:0]  sext_o
);
    localparam int LOW_W = W - UW;
    localparam int EXT_W = W - SW;

    // Shift upper field into place, replicate sign of short field.
    always_comb begin
        upper_o = {uimm_i, {LOW_W{1'b0}}};
        sext_o  = {{EXT_W{simm_i[SW-1]}}, simm_i};
    end
endmodule

// File: rtl/ue_cmp.sv
// Less-than comparator, signed or unsigned chosen per use.
// Assumes two's-complement operands of equal width.
module ue_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic         lt_o
);
    logic ult;

    // Unsigned compare; on a sign mismatch the signed answer is a's sign.
    always_comb begin
        ult = (a_i < b_i);
        if (signed_i && (a_i[W-1] != b_i[W-1]))
            lt_o = a_i[W-1];
        else
            lt_o = ult;
    end
endmodule

// File: rtl/ue_addr.sv
// Address adders: register-plus-offset (shared by add immediate and jump),
// PC-plus-upper, and the link value PC plus one instruction.
// Assumes instructions are INSN_BYTES wide; sums wrap.
module ue_addr #(
    parameter int W          = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] sext_i,
    input  logic [W-1:0] upper_i,
    output logic [W-1:0] reg_sum_o,
    output logic [W-1:0] pc_sum_o,
    output logic [W-1:0] link_o,
    output logic [W-1:0] jtgt_o
);
    localparam logic [W-1:0] STEP = W'(INSN_BYTES);

    // Three independent adders and the even-aligned jump target.
    always_comb begin
        reg_sum_o = base_i + sext_i;
        pc_sum_o  = pc_i + upper_i;
        link_o    = pc_i + STEP;
        jtgt_o    = {reg_sum_o[W-1:1], 1'b0};
    end
endmodule

// File: rtl/ue_exec.sv
// Execute unit top: selects the write-back value, write-enable and
// redirect among upper-immediate, add-immediate, jump and compare ops.
// Purely combinational; unused op codes behave as idle.
module ue_exec
    import ue_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int UW = UIMM_W,
    parameter int SW = SIMM_W,
    parameter int RW = RIDX_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    pc_i,
    input  logic [W-1:0]    rs1_i,
    input  logic [W-1:0]    rs2_i,
    input  logic [UW-1:0]   imm20_i,
    input  logic [SW-1:0]   imm12_i,
    input  logic [RW-1:0]   rd_i,
    output logic [W-1:0]    wr_val_o,
    output logic            wr_en_o,
    output logic            redirect_o,
    output logic [W-1:0]    target_o
);
    ue_op_e     op;
    logic [W-1:0] upper, sext, reg_sum, pc_sum, link, jtgt, cmp_b;
    logic       cmp_signed, lt, writes;

    // Decode the raw code into the op type.
    always_comb op = ue_op_e'(op_i);

    ue_imm #(.W(W), .UW(UW), .SW(SW)) u_imm (
        .uimm_i  (imm20_i),
        .simm_i  (imm12_i),
        .upper_o (upper),
        .sext_o  (sext)
    );

    ue_addr #(.W(W), .INSN_BYTES(4)) u_addr (
        .pc_i      (pc_i),
        .base_i    (rs1_i),
        .sext_i    (sext),
        .upper_i   (upper),
        .reg_sum_o (reg_sum),
        .pc_sum_o  (pc_sum),
        .link_o    (link),
        .jtgt_o    (jtgt)
    );

    // Choose comparator operand and signedness from the op.
    always_comb begin
        cmp_b      = ((op == OP_SLTI) || (op == OP_SLTIU)) ? sext : rs2_i;
        cmp_signed = (op == OP_SLT) || (op == OP_SLTI);
    end

    ue_cmp #(.W(W)) u_cmp (
        .a_i      (rs1_i),
        .b_i      (cmp_b),
        .signed_i (cmp_signed),
        .lt_o     (lt)
    );

    // Result select, write qualification and redirect.
    always_comb begin
        wr_val_o   = '0;
        writes     = 1'b1;
        redirect_o = 1'b0;
        target_o   = '0;
        case (op)
            OP_LUI:   wr_val_o = upper;
            OP_AUIPC: wr_val_o = pc_sum;
            OP_ADDI:  wr_val_o = reg_sum;
            OP_JALR: begin
                wr_val_o   = link;
                redirect_o = 1'b1;
                target_o   = jtgt;
            end
            OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU:
                wr_val_o = W'(lt);
            default:  writes = 1'b0;
        endcase
        wr_en_o = writes && (rd_i != '0);
    end
endmodule

// File: rtl/ue_exec_chk.sv
// Checker for the execute unit, evaluated on settled combinational values.
// Assumes two-state inputs; attached to every ue_exec by bind.
module ue_exec_chk #(
    parameter int W  = 32,
    parameter int UW = 20,
    parameter int RW = 5
) (
    input logic [3:0]    op_i,
    input logic [W-1:0]  pc_i,
    input logic [RW-1:0] rd_i,
    input logic [W-1:0]  wr_val_o,
    input logic          wr_en_o,
    input logic          redirect_o,
    input logic [W-1:0]  target_o
);
    localparam int LOW_W = W - UW;

    // Output invariants across all op codes.
    always_comb begin
        if (op_i == 4'd1)
            AST_LUI_LOW_CLEAR: assert (wr_val_o[LOW_W-1:0] == '0); // R1
        if (op_i == 4'd2)
            AST_AUIPC_LOW_PC: assert (wr_val_o[LOW_W-1:0] == pc_i[LOW_W-1:0]); // R2
        if (op_i == 4'd4)
            AST_JUMP_EVEN: assert (redirect_o && !target_o[0]); // R4
        if (op_i >= 4'd5 && op_i <= 4'd8)
            AST_CMP_BOOL: assert (wr_val_o[W-1:1] == '0); // R5
        if (rd_i == '0)
            AST_X0_NO_WRITE: assert (!wr_en_o); // R7
        if (op_i != 4'd4)
            AST_NO_REDIRECT: assert (!redirect_o && target_o == '0); // R8
        if (op_i == 4'd0 || op_i > 4'd8)
            AST_IDLE_QUIET: assert (!wr_en_o && wr_val_o == '0); // R8
    end
endmodule

bind ue_exec ue_exec_chk #(.W(W), .UW(UW), .RW(RW)) u_chk (
    .op_i       (op_i),
    .pc_i       (pc_i),
    .rd_i       (rd_i),
    .wr_val_o   (wr_val_o),
    .wr_en_o    (wr_en_o),
    .redirect_o (redirect_o),
    .target_o   (target_o)
);

// File: tb/ue_exec_tb.sv
module ue_exec_tb;
    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] pc;
        logic [31:0] rs1;
        logic [31:0] rs2;
        logic [19:0] i20;
        logic [11:0] i12;
        logic [4:0]  rd;
        logic [31:0] ev;
        logic        een;
        logic        ered;
        logic [31:0] etg;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{4'd1, 32'h0, 32'h0, 32'h0, 20'h12345, 12'h0, 5'd1, 32'h12345000, 1'b1, 1'b0, 32'h0, 4'd1},        // R1
        '{4'd1, 32'h0, 32'h0, 32'h0, 20'hFFFFF, 12'hABC, 5'd3, 32'hFFFFF000, 1'b1, 1'b0, 32'h0, 4'd1},      // R1
        '{4'd2, 32'h8, 32'h0, 32'h0, 20'h10000, 12'h0, 5'd10, 32'h10000008, 1'b1, 1'b0, 32'h0, 4'd2},       // R2
        '{4'd2, 32'hFFFFF004, 32'h0, 32'h0, 20'h00002, 12'h0, 5'd4, 32'h00001004, 1'b1, 1'b0, 32'h0, 4'd2}, // R2 wrap
        '{4'd3, 32'h0, 32'h10, 32'h0, 20'h0, 12'hFFF, 5'd5, 32'h0000000F, 1'b1, 1'b0, 32'h0, 4'd3},         // R3
        '{4'd3, 32'h0, 32'h0, 32'h0, 20'h0, 12'h7FF, 5'd5, 32'h000007FF, 1'b1, 1'b0, 32'h0, 4'd3},          // R3
        '{4'd4, 32'h100, 32'h2001, 32'h0, 20'h0, 12'h004, 5'd1, 32'h104, 1'b1, 1'b1, 32'h2004, 4'd4},       // R4 odd
        '{4'd4, 32'h40, 32'h1000, 32'h0, 20'h0, 12'h800, 5'd0, 32'h44, 1'b0, 1'b1, 32'h800, 4'd4},          // R4 neg, R7
        '{4'd5, 32'h0, 32'hFFFFFFFF, 32'h1, 20'h0, 12'h0, 5'd6, 32'h1, 1'b1, 1'b0, 32'h0, 4'd5},            // R5
        '{4'd6, 32'h0, 32'hFFFFFFFF, 32'h1, 20'h0, 12'h0, 5'd6, 32'h0, 1'b1, 1'b0, 32'h0, 4'd5},            // R5
        '{4'd5, 32'h0, 32'h7, 32'h7, 20'h0, 12'h0, 5'd6, 32'h0, 1'b1, 1'b0, 32'h0, 4'd5},                   // R5 equal
        '{4'd7, 32'h0, 32'h5, 32'h0, 20'h0, 12'hFFF, 5'd7, 32'h0, 1'b1, 1'b0, 32'h0, 4'd6},                 // R6
        '{4'd8, 32'h0, 32'h5, 32'h0, 20'h0, 12'hFFF, 5'd7, 32'h1, 1'b1, 1'b0, 32'h0, 4'd6},                 // R6
        '{4'd8, 32'h0, 32'hFFFFFFFE, 32'h0, 20'h0, 12'hFFF, 5'd7, 32'h1, 1'b1, 1'b0, 32'h0, 4'd6},          // R6
        '{4'd7, 32'h0, 32'hFFFFFFFE, 32'h0, 20'h0, 12'hFFF, 5'd7, 32'h1, 1'b1, 1'b0, 32'h0, 4'd6},          // R6
        '{4'd1, 32'h0, 32'h0, 32'h0, 20'h12345, 12'h0, 5'd0, 32'h12345000, 1'b0, 1'b0, 32'h0, 4'd7},        // R7
        '{4'd5, 32'h0, 32'h1, 32'h2, 20'h0, 12'h0, 5'd0, 32'h1, 1'b0, 1'b0, 32'h0, 4'd7},                   // R7
        '{4'd0, 32'h8, 32'h5, 32'h6, 20'h11111, 12'h123, 5'd9, 32'h0, 1'b0, 1'b0, 32'h0, 4'd8},             // R8
        '{4'd9, 32'h8, 32'h5, 32'h6, 20'h11111, 12'h123, 5'd9, 32'h0, 1'b0, 1'b0, 32'h0, 4'd8},             // R8
        '{4'd15, 32'h8, 32'h5, 32'h6, 20'h11111, 12'h123, 5'd9, 32'h0, 1'b0, 1'b0, 32'h0, 4'd8}             // R8
    };

    logic        clk = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] pc_i = '0, rs1_i = '0, rs2_i = '0;
    logic [19:0] imm20_i = '0;
    logic [11:0] imm12_i = '0;
    logic [4:0]  rd_i = '0;
    logic [31:0] wr_val_o, target_o;
    logic        wr_en_o, redirect_o;
    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ue_exec u_dut (
        .op_i(op_i), .pc_i(pc_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
        .imm20_i(imm20_i), .imm12_i(imm12_i), .rd_i(rd_i),
        .wr_val_o(wr_val_o), .wr_en_o(wr_en_o),
        .redirect_o(redirect_o), .target_o(target_o)
    );

    task automatic drive(input logic [3:0] op, input logic [31:0] pc, input logic [31:0] a,
                         input logic [31:0] b, input logic [19:0] u, input logic [11:0] s,
                         input logic [4:0] rd);
        @(posedge clk);
        op_i = op; pc_i = pc; rs1_i = a; rs2_i = b; imm20_i = u; imm12_i = s; rd_i = rd;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] ev, input logic een,
                         input logic ered, input logic [31:0] etg);
        checks++;
        if (wr_val_o !== ev || wr_en_o !== een || redirect_o !== ered || target_o !== etg) begin
            errors++;
            $display("FAIL %s: got val=%h en=%b red=%b tgt=%h, expected val=%h en=%b red=%b tgt=%h",
                     tag, wr_val_o, wr_en_o, redirect_o, target_o, ev, een, ered, etg);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] x10;
        // Startup with idle op: all outputs quiet (R8).
        @(negedge clk);
        check("R8 startup idle", 32'h0, 1'b0, 1'b0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VT[i].op, VT[i].pc, VT[i].rs1, VT[i].rs2, VT[i].i20, VT[i].i12, VT[i].rd);
            check($sformatf("R%0d vector %0d", VT[i].req, i), VT[i].ev, VT[i].een, VT[i].ered, VT[i].etg);
        end

        // Far data address pair: R2 then R3.
        drive(4'd2, 32'h8, 32'h0, 32'h0, 20'h10000, 12'h0, 5'd10);
        check("R2 pair step", 32'h10000008, 1'b1, 1'b0, 32'h0);
        x10 = wr_val_o;
        drive(4'd3, 32'hC, x10, 32'h0, 20'h0, 12'h018, 5'd10);
        check("R3 pair add", 32'h10000020, 1'b1, 1'b0, 32'h0);

        // Far jump pair: R2 then R4.
        drive(4'd2, 32'h8, 32'h0, 32'h0, 20'h7FFFF, 12'h0, 5'd10);
        check("R2 jump base", 32'h7FFFF008, 1'b1, 1'b0, 32'h0);
        x10 = wr_val_o;
        drive(4'd4, 32'hC, x10, 32'h0, 20'h0, 12'h010, 5'd1);
        check("R4 far jump", 32'h00000010, 1'b1, 1'b1, 32'h7FFFF018);

        // Random comparisons, signed and unsigned, register and immediate (R5, R6).
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a, b, se;
            logic [11:0] s;
            logic [3:0]  op;
            logic        exp;
            a  = $urandom;
            b  = (k % 5 == 0) ? a : $urandom;
            s  = 12'($urandom);
            se = {{20{s[11]}}, s};
            op = 4'(5 + (k % 4));
            case (op)
                4'd5: exp = $signed(a) < $signed(b);
                4'd6: exp = a < b;
                4'd7: exp = $signed(a) < $signed(se);
                default: exp = a < se;
            endcase
            drive(op, $urandom, a, b, 20'($urandom), s, 5'd2);
            check(op < 4'd7 ? "R5 random" : "R6 random", {31'b0, exp}, 1'b1, 1'b0, 32'h0);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule